// File: doc/BRIEF.md
# Double-Buffered Receive Frame Store

This block sits between a bit-level bus receiver and the processor. Each time the receiver finishes a frame that passed its error checks, it presents the frame for one cycle. The frame comes with a vector that has one bit per identifier acceptance filter, and a set bit means that filter matched. A frame that matched no filter is dropped. A matched frame goes into a processor-visible foreground buffer if that buffer is free. Otherwise it waits in a background buffer. When a frame arrives and both buffers already hold unread frames, the new frame is discarded and a sticky overrun flag is set.

The processor reads the foreground frame from the output ports. These ports also give the index of the lowest-numbered filter that matched. A one-cycle release pulse frees the foreground buffer. If a background frame is waiting, it moves forward one cycle after the release, and the full flag rises again. Two interrupt lines combine the full and overrun flags with their enable inputs.

A four-state machine tracks buffer occupancy:
- `RX_EMPTY`: no frame is held.
- `RX_HELD`: the foreground holds a frame.
- `RX_BOTH`: the foreground and the background both hold frames.
- `RX_SHIFT`: the foreground was just released and the background frame is moving forward.

The transitions are:
- EMPTY→HELD on an accepted frame.
- HELD→BOTH on an accepted frame.
- HELD→EMPTY on a release.
- HELD→HELD on a release and an accepted frame in the same cycle (the new frame replaces the foreground).
- BOTH→SHIFT on a release.
- BOTH→BOTH on an accepted frame (overrun).
- SHIFT→HELD on its own.
- SHIFT→BOTH when a frame is accepted during the shift.

Top module: `rxq_dual_buffer`

## Requirements
- R1: After reset, `rx_full`, `ovr_flag`, `irq_rx` and `irq_ovr` are all 0.
- R2: A frame is accepted when `in_valid`=1 and at least one bit of `in_hit` is 1. If no frame is held, an accepted frame appears on the `fg_*` outputs and `rx_full`=1 at the first clock edge after it.
- R3: A frame with `in_hit` all zero is dropped. `rx_full`, `ovr_flag` and the `fg_*` outputs do not change.
- R4: A frame accepted while the foreground holds a frame and no background frame waits is kept in the background. The `fg_*` outputs and `rx_full`=1 do not change.
- R5: A `cpu_release` pulse while a frame is held and no background frame waits makes `rx_full`=0 after the next edge.
- R6: A `cpu_release` pulse while a background frame waits makes `rx_full`=0 for exactly one cycle. After the second edge, the waiting frame is on the `fg_*` outputs and `rx_full`=1.
- R7: A frame accepted while both buffers hold frames sets `ovr_flag` after the next edge and is discarded. The foreground frame and the waiting background frame are kept.
- R8: `ovr_flag` stays 1 until an `ovr_clear` pulse clears it. If an overrun and `ovr_clear` happen in the same cycle, the flag is set.
- R9: `irq_rx` = `rx_full` AND `rxf_ie`, and `irq_ovr` = `ovr_flag` AND `ovr_ie`.
- R10: `fg_hit_idx` gives the binary index of the lowest-numbered set bit of `in_hit` for the held frame (bit 0 is filter 0).
- R11: A standard-format frame (`in_ext`=0) is stored with identifier bits 28 down to 11 forced to 0. An extended frame (`in_ext`=1) keeps all 29 bits.
- R12: A `cpu_release` and an accepted frame in the same cycle, while a frame is held and no background frame waits, replace the foreground with the new frame, and `rx_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle strobe: a completed error-free frame is present |
| in_id | input | 29 | Frame identifier |
| in_ext | input | 1 | 1 = extended 29-bit identifier, 0 = standard 11-bit |
| in_rtr | input | 1 | Remote request bit of the frame |
| in_dlc | input | 4 | Data length code |
| in_data | input | 64 | Data bytes |
| in_hit | input | 8 | Per-filter match vector |
| cpu_release | input | 1 | Pulse that frees the foreground buffer |
| ovr_clear | input | 1 | Pulse that clears the overrun flag |
| rxf_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rx_full | output | 1 | Foreground holds an unread frame |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| fg_id | output | 29 | Foreground identifier |
| fg_ext | output | 1 | Foreground format bit |
| fg_rtr | output | 1 | Foreground remote request bit |
| fg_dlc | output | 4 | Foreground data length code |
| fg_data | output | 64 | Foreground data bytes |
| fg_hit_idx | output | 3 | Index of the lowest matching filter |

## Verification
The assertions check the following on every cycle:
- An accept from empty fills the foreground on the next edge.
- An overrun sets the flag.
- The flag is sticky.
- A release with a waiting frame goes through one empty cycle and then refills.
- A frame with no filter match leaves the flags and the foreground data untouched.
- The encoded hit index points at a set bit.

Only the bench's scenarios can show the following:
- The discarded overrun frame never reaches the foreground.
- The older background frame surfaces in order.
- Standard identifiers are masked.
- A release and a new frame in the same cycle swap the foreground.
- The interrupt gating behaves as specified.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        RX_EMPTY = 2'd0,
        RX_HELD  = 2'd1,
        RX_BOTH  = 2'd2,
        RX_SHIFT = 2'd3
    } rxq_state_e;
endpackage

// File: rtl/rxq_hit_encoder.sv
module rxq_hit_encoder #(
    parameter int NFILT = 8,
    localparam int HIT_W = (NFILT > 1) ? $clog2(NFILT) : 1
) (
    input  logic [NFILT-1:0] hit,
    output logic             any,
    output logic [HIT_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NFILT - 1; i >= 0; i--) begin
            if (hit[i]) idx = HIT_W'(i);
        end
    end
    assign any = |hit;

    // R10: the encoded index always names a matching filter
    always_comb begin
        if (any) assert_idx_is_hit_R10: assert (hit[idx]);
    end
endmodule

// File: rtl/rxq_slot.sv
module rxq_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic release_req,
    input  logic ovr_clear,
    output logic fg_load,
    output logic fg_from_bg,
    output logic bg_load,
    output logic promote,
    output logic rx_full,
    output logic ovr_flag
);
    rxq_state_e st_q, st_d;
    logic       ovr_set;
    logic       ovr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    // next state and buffer controls
    always_comb begin
        st_d       = st_q;
        fg_load    = 1'b0;
        fg_from_bg = 1'b0;
        bg_load    = 1'b0;
        ovr_set    = 1'b0;
        unique case (st_q)
            RX_EMPTY: begin
                if (accept) begin
                    fg_load = 1'b1;
                    st_d    = RX_HELD;
                end
            end
            RX_HELD: begin
                if (release_req && accept) begin
                    fg_load = 1'b1;
                end else if (release_req) begin
                    st_d = RX_EMPTY;
                end else if (accept) begin
                    bg_load = 1'b1;
                    st_d    = RX_BOTH;
                end
            end
            RX_BOTH: begin
                if (accept)      ovr_set = 1'b1;
                if (release_req) st_d    = RX_SHIFT;
            end
            RX_SHIFT: begin
                fg_load    = 1'b1;
                fg_from_bg = 1'b1;
                if (accept) begin
                    bg_load = 1'b1;
                    st_d    = RX_BOTH;
                end else begin
                    st_d = RX_HELD;
                end
            end
            default: st_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovr_q <= 1'b0;
        else if (ovr_set)   ovr_q <= 1'b1;
        else if (ovr_clear) ovr_q <= 1'b0;
    end

    // outputs
    always_comb begin
        rx_full  = (st_q == RX_HELD) || (st_q == RX_BOTH);
        promote  = (st_q == RX_SHIFT);
        ovr_flag = ovr_q;
    end

    assert_fill_from_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_EMPTY && accept) |=> rx_full);
    assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_BOTH && accept) |=> ovr_flag);
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag);
    assert_shift_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_BOTH && release_req) |=> (!rx_full ##1 rx_full));
    assert_release_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_HELD && release_req && !accept) |=> !rx_full);
endmodule

// File: rtl/rxq_dual_buffer.sv
module rxq_dual_buffer #(
    parameter int ID_W   = 29,
    parameter int STD_W  = 11,
    parameter int NBYTES = 8,
    parameter int NFILT  = 8,
    localparam int HIT_W  = (NFILT > 1) ? $clog2(NFILT) : 1,
    localparam int DATA_W = 8 * NBYTES,
    localparam int FRM_W  = HIT_W + 1 + 1 + 4 + DATA_W + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_id,
    input  logic              in_ext,
    input  logic              in_rtr,
    input  logic [3:0]        in_dlc,
    input  logic [DATA_W-1:0] in_data,
    input  logic [NFILT-1:0]  in_hit,
    input  logic              cpu_release,
    input  logic              ovr_clear,
    input  logic              rxf_ie,
    input  logic              ovr_ie,
    output logic              rx_full,
    output logic              ovr_flag,
    output logic              irq_rx,
    output logic              irq_ovr,
    output logic [ID_W-1:0]   fg_id,
    output logic              fg_ext,
    output logic              fg_rtr,
    output logic [3:0]        fg_dlc,
    output logic [DATA_W-1:0] fg_data,
    output logic [HIT_W-1:0]  fg_hit_idx
);
    logic             hit_any;
    logic [HIT_W-1:0] hit_idx;
    logic             accept;
    logic             fg_load, fg_from_bg, bg_load, promote;
    logic [ID_W-1:0]  id_kept;
    logic [FRM_W-1:0] in_word, bg_q, fg_d, fg_q;

    rxq_hit_encoder #(.NFILT(NFILT)) u_enc (
        .hit (in_hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign accept = in_valid && hit_any;

    // standard identifiers keep only their low bits
    for (genvar b = 0; b < ID_W; b++) begin : g_idmask
        if (b < STD_W) begin : g_low
            assign id_kept[b] = in_id[b];
        end else begin : g_high
            assign id_kept[b] = in_id[b] & in_ext;
        end
    end

    assign in_word = {hit_idx, in_ext, in_rtr, in_dlc, in_data, id_kept};
    assign fg_d    = fg_from_bg ? bg_q : in_word;

    rxq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .release_req (cpu_release),
        .ovr_clear   (ovr_clear),
        .fg_load     (fg_load),
        .fg_from_bg  (fg_from_bg),
        .bg_load     (bg_load),
        .promote     (promote),
        .rx_full     (rx_full),
        .ovr_flag    (ovr_flag)
    );

    rxq_slot #(.W(FRM_W)) u_bg (
        .clk (clk), .rst_n (rst_n), .load (bg_load), .din (in_word), .q (bg_q)
    );
    rxq_slot #(.W(FRM_W)) u_fg (
        .clk (clk), .rst_n (rst_n), .load (fg_load), .din (fg_d), .q (fg_q)
    );

    assign {fg_hit_idx, fg_ext, fg_rtr, fg_dlc, fg_data, fg_id} = fg_q;
    assign irq_rx  = rx_full && rxf_ie;
    assign irq_ovr = ovr_flag && ovr_ie;

    assert_nomatch_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(|in_hit) && !cpu_release && !ovr_clear && !promote)
        |=> ($stable(rx_full) && $stable(ovr_flag) && $stable(fg_data)));
endmodule

// File: tb/rxq_dual_buffer_tb.sv
`timescale 1ns/1ps
module rxq_dual_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [28:0] in_id = '0;
    logic        in_ext = 1'b0;
    logic        in_rtr = 1'b0;
    logic [3:0]  in_dlc = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_hit = '0;
    logic        cpu_release = 1'b0;
    logic        ovr_clear = 1'b0;
    logic        rxf_ie = 1'b1;
    logic        ovr_ie = 1'b1;
    logic        rx_full, ovr_flag, irq_rx, irq_ovr, fg_ext, fg_rtr;
    logic [28:0] fg_id;
    logic [3:0]  fg_dlc;
    logic [63:0] fg_data;
    logic [2:0]  fg_hit_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rxq_dual_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
        .in_ext(in_ext), .in_rtr(in_rtr), .in_dlc(in_dlc), .in_data(in_data),
        .in_hit(in_hit), .cpu_release(cpu_release), .ovr_clear(ovr_clear),
        .rxf_ie(rxf_ie), .ovr_ie(ovr_ie), .rx_full(rx_full), .ovr_flag(ovr_flag),
        .irq_rx(irq_rx), .irq_ovr(irq_ovr), .fg_id(fg_id), .fg_ext(fg_ext),
        .fg_rtr(fg_rtr), .fg_dlc(fg_dlc), .fg_data(fg_data), .fg_hit_idx(fg_hit_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle from a negedge; outputs are sampled at the following negedge
    task automatic cycle(input logic v, input logic [28:0] id, input logic ext,
                         input logic [63:0] d, input logic [7:0] hit,
                         input logic rel, input logic clr);
        in_valid = v; in_id = id; in_ext = ext; in_data = d; in_hit = hit;
        in_dlc = 4'd8; in_rtr = 1'b0; cpu_release = rel; ovr_clear = clr;
        @(negedge clk);
        in_valid = 1'b0; in_hit = '0; cpu_release = 1'b0; ovr_clear = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rx_full", {63'd0, rx_full}, 64'd0);
        chk("R1 ovr_flag", {63'd0, ovr_flag}, 64'd0);
        chk("R1 irq_rx", {63'd0, irq_rx}, 64'd0);
        chk("R1 irq_ovr", {63'd0, irq_ovr}, 64'd0);
    endtask

    task automatic t_first_frame;
        cycle(1'b1, 29'h123, 1'b0, 64'hAAAA_0001, 8'b0010_0100, 1'b0, 1'b0);
        chk("R2 rx_full", {63'd0, rx_full}, 64'd1);
        chk("R2 fg_data", fg_data, 64'hAAAA_0001);
        chk("R10 hit idx", {61'd0, fg_hit_idx}, 64'd2);
        chk("R9 irq_rx on", {63'd0, irq_rx}, 64'd1);
    endtask

    task automatic t_no_match;
        cycle(1'b1, 29'h55, 1'b0, 64'hBBBB_0002, 8'h00, 1'b0, 1'b0);
        chk("R3 fg_data kept", fg_data, 64'hAAAA_0001);
        chk("R3 rx_full", {63'd0, rx_full}, 64'd1);
        chk("R3 ovr_flag", {63'd0, ovr_flag}, 64'd0);
    endtask

    task automatic t_background_and_overrun;
        cycle(1'b1, 29'h10, 1'b0, 64'hCCCC_0003, 8'b1000_0000, 1'b0, 1'b0);
        chk("R4 fg_data kept", fg_data, 64'hAAAA_0001);
        chk("R4 rx_full", {63'd0, rx_full}, 64'd1);
        chk("R4 no ovr", {63'd0, ovr_flag}, 64'd0);
        cycle(1'b1, 29'h11, 1'b0, 64'hDDDD_0004, 8'b0000_0001, 1'b0, 1'b0);
        chk("R7 ovr_flag", {63'd0, ovr_flag}, 64'd1);
        chk("R7 fg_data kept", fg_data, 64'hAAAA_0001);
        chk("R9 irq_ovr on", {63'd0, irq_ovr}, 64'd1);
        cycle(1'b0, '0, 1'b0, '0, 8'h00, 1'b1, 1'b0);
        chk("R6 gap cycle", {63'd0, rx_full}, 64'd0);
        @(negedge clk);
        chk("R6 refilled", {63'd0, rx_full}, 64'd1);
        chk("R7 background survives", fg_data, 64'hCCCC_0003);
        chk("R10 promoted idx", {61'd0, fg_hit_idx}, 64'd7);
        chk("R8 sticky", {63'd0, ovr_flag}, 64'd1);
    endtask

    task automatic t_ovr_clear;
        cycle(1'b0, '0, 1'b0, '0, 8'h00, 1'b0, 1'b1);
        chk("R8 cleared", {63'd0, ovr_flag}, 64'd0);
        cycle(1'b1, 29'h20, 1'b0, 64'hEEEE_0005, 8'h02, 1'b0, 1'b0);
        cycle(1'b1, 29'h21, 1'b0, 64'hFFFF_0006, 8'h02, 1'b0, 1'b1);
        chk("R8 set wins over clear", {63'd0, ovr_flag}, 64'd1);
        cycle(1'b0, '0, 1'b0, '0, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        chk("R6 next frame", fg_data, 64'hEEEE_0005);
        cycle(1'b0, '0, 1'b0, '0, 8'h00, 1'b1, 1'b0);
        chk("R5 released", {63'd0, rx_full}, 64'd0);
        chk("R8 cleared again", {63'd0, ovr_flag}, 64'd0);
    endtask

    task automatic t_id_format_and_swap;
        cycle(1'b1, 29'h1FFF_FFFF, 1'b0, 64'h1, 8'h01, 1'b0, 1'b0);
        chk("R11 standard masked", {35'd0, fg_id}, 64'h7FF);
        cycle(1'b1, 29'h1ABC_DEF1, 1'b1, 64'h2, 8'h01, 1'b1, 1'b0);
        chk("R12 rx_full stays", {63'd0, rx_full}, 64'd1);
        chk("R12 swapped data", fg_data, 64'h2);
        chk("R11 extended kept", {35'd0, fg_id}, 64'h1ABC_DEF1);
        rxf_ie = 1'b0;
        #1;
        chk("R9 irq_rx gated", {63'd0, irq_rx}, 64'd0);
        cycle(1'b0, '0, 1'b0, '0, 8'h00, 1'b1, 1'b0);
        chk("R5 empty", {63'd0, rx_full}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_frame();
        t_no_match();
        t_background_and_overrun();
        t_ovr_clear();
        t_id_format_and_swap();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule